// File: doc/BRIEF.md
# Dual-Bridge I/O Window Router

This block decides where each upstream I/O request goes. Two downstream bridge functions sit behind it, and each bridge owns an I/O window. A window is defined by a programmable base and a programmable limit. Both are kept at 4 KB granularity, and only a 16-bit I/O address space is supported. A request carries a 16-bit address and a valid strobe. One clock later the block reports one of three outcomes: forward to bridge 0, forward to bridge 1, or Unsupported Request (UR).

Software programs the windows through a byte-wide configuration port. A select input chooses the bridge. Byte offset 1Ch holds the base field and byte offset 1Dh holds the limit field. In both bytes the 4-bit field sits in bits [7:4], and bits [3:0] always read as zero. The wide upper base and limit registers at offsets 30h and 32h do not exist. They read as zero and ignore writes, and so does every other offset. Keeping the two windows apart is left to software. If they do overlap, bridge 0 wins.

Top module: `ioWindowRouter`

## Requirements
- R1: After reset every bridge's base byte (offset 1Ch) and limit byte (offset 1Dh) read 00h, so each window covers addresses 0000h to 0FFFh.
- R2: Writing offset 1Ch for the selected bridge stores data bits [7:4] as that bridge's base field. A read of 1Ch returns the field in bits [7:4] with bits [3:0] zero.
- R3: Writing offset 1Dh for the selected bridge stores data bits [7:4] as that bridge's limit field. A read of 1Dh returns the field in bits [7:4] with bits [3:0] zero.
- R4: Offsets 30h to 33h, and every offset other than 1Ch and 1Dh, read 00h. Writes to them change no stored field and no routing result.
- R5: A bridge's window matches an address A when {base,000h} <= A <= {limit,FFFh}, with both bounds inclusive.
- R6: A request whose address matches no window returns result code 3 (UR).
- R7: A request that matches both windows is routed to bridge 0 (code 1). A match of bridge 1 alone returns code 2.
- R8: A window whose base field is greater than its limit field matches no address.
- R9: rspValid is high exactly in the cycle after a cycle with reqValid high, and only then. rspCode is 0 whenever rspValid is low.
- R10: A configuration write in the same cycle as a request does not affect that request. It affects only requests in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSel | input | 1 | Bridge chosen by the configuration port |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgOffset | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration write byte |
| cfgRdData | output | 8 | Configuration read byte, combinational from cfgSel and cfgOffset |
| reqValid | input | 1 | Request valid strobe |
| reqAddr | input | 16 | Request I/O address |
| rspValid | output | 1 | Result valid pulse, one cycle after reqValid |
| rspCode | output | 2 | 0 idle, 1 bridge 0, 2 bridge 1, 3 UR |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-result timing and the idle code;
- the zero low nibble of every configuration read;
- zero reads from unimplemented offsets;
- that bridge 0 wins whenever it hits;
- that an inverted window never claims a request.

Only the bench's scenarios can show the window arithmetic itself: the inclusive 4 KB bounds at both edges, UR for the gaps between windows, ignored writes to offsets 30h through 33h, and a write that lands in the same cycle as a request.

// File: rtl/ioWinPkg.sv
package ioWinPkg;
  localparam int BR_CNT = 2;
  localparam int SEL_W = (BR_CNT > 1) ? $clog2(BR_CNT) : 1;
  localparam int CODE_W = $clog2(BR_CNT + 2);
  localparam logic [7:0] OFF_BASE = 8'h1C;
  localparam logic [7:0] OFF_LIMIT = 8'h1D;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_BASE  = 2'd1,
    RD_LIMIT = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic [BR_CNT-1:0] baseWe;
    logic [BR_CNT-1:0] limitWe;
    rdSrc_e rdSrc;
    logic lookup;
  } ctrlStrobes_t;
endpackage

// File: rtl/ioWinCtrl.sv
module ioWinCtrl
  import ioWinPkg::*;
(
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgOffset,
  input  logic             reqValid,
  output ctrlStrobes_t     strb
);
  always_comb begin
    strb = '0;
    strb.rdSrc = RD_ZERO;
    strb.lookup = reqValid;
    unique case (cfgOffset)
      OFF_BASE: begin
        strb.rdSrc = RD_BASE;
        for (int i = 0; i < BR_CNT; i++)
          strb.baseWe[i] = cfgWrEn && (cfgSel == SEL_W'(i));
      end
      OFF_LIMIT: begin
        strb.rdSrc = RD_LIMIT;
        for (int i = 0; i < BR_CNT; i++)
          strb.limitWe[i] = cfgWrEn && (cfgSel == SEL_W'(i));
      end
      default: strb.rdSrc = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/ioWinDatapath.sv
module ioWinDatapath
  import ioWinPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [7:0]        cfgOffset,
  input  logic [7:0]        cfgWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        cfgRdData,
  output logic              rspValid,
  output logic [CODE_W-1:0] rspCode
);
  localparam int NIB_W = ADDR_W - WIN_W;
  localparam logic [CODE_W-1:0] CODE_UR = CODE_W'(BR_CNT + 1);

  logic [NIB_W-1:0] baseNib [BR_CNT];
  logic [NIB_W-1:0] limitNib [BR_CNT];
  logic [BR_CNT-1:0] hit;
  logic [CODE_W-1:0] nextCode;
  logic [NIB_W-1:0] reqNib;
  logic unusedLowBits;

  assign reqNib = reqAddr[ADDR_W-1 -: NIB_W];
  assign unusedLowBits = ^{cfgWrData[7-NIB_W:0], reqAddr[WIN_W-1:0]};

  // Per-bridge window registers and comparators.
  for (genvar g = 0; g < BR_CNT; g++) begin : gBridge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseNib[g] <= '0;
        limitNib[g] <= '0;
      end else begin
        if (strb.baseWe[g]) baseNib[g] <= cfgWrData[7 -: NIB_W];
        if (strb.limitWe[g]) limitNib[g] <= cfgWrData[7 -: NIB_W];
      end
    end
    assign hit[g] = (reqNib >= baseNib[g]) && (reqNib <= limitNib[g]);
  end

  // Lowest-numbered bridge wins.
  always_comb begin
    nextCode = CODE_UR;
    for (int i = BR_CNT - 1; i >= 0; i--)
      if (hit[i]) nextCode = CODE_W'(i + 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode <= '0;
    end else begin
      rspValid <= strb.lookup;
      rspCode <= strb.lookup ? nextCode : '0;
    end
  end

  always_comb begin
    unique case (strb.rdSrc)
      RD_BASE:  cfgRdData = {baseNib[cfgSel], {(8-NIB_W){1'b0}}};
      RD_LIMIT: cfgRdData = {limitNib[cfgSel], {(8-NIB_W){1'b0}}};
      default:  cfgRdData = 8'h00;
    endcase
  end

  a_r9_rsp_after_req: assert property (@(posedge clk) disable iff (!rstN)
    strb.lookup |=> rspValid);
  a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lookup |=> !rspValid);
  a_r9_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> rspCode == '0);
  a_r6_code_valid: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspCode != '0);
  a_r2_low_nibble_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[7-NIB_W:0] == '0);
  a_r4_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOffset != OFF_BASE && cfgOffset != OFF_LIMIT) |-> cfgRdData == 8'h00);
  a_r7_bridge0_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lookup && hit[0]) |=> rspCode == CODE_W'(1));
  a_r8_inverted_no_claim: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lookup && baseNib[0] > limitNib[0]) |=> rspCode != CODE_W'(1));
endmodule

// File: rtl/ioWindowRouter.sv
module ioWindowRouter
  import ioWinPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgOffset,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [CODE_W-1:0] rspCode
);
  ctrlStrobes_t strb;

  ioWinCtrl u_ctrl (
    .cfgSel(cfgSel), .cfgWrEn(cfgWrEn), .cfgOffset(cfgOffset),
    .reqValid(reqValid), .strb(strb)
  );

  ioWinDatapath #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgSel(cfgSel),
    .cfgOffset(cfgOffset), .cfgWrData(cfgWrData), .reqAddr(reqAddr),
    .cfgRdData(cfgRdData), .rspValid(rspValid), .rspCode(rspCode)
  );
endmodule

// File: tb/test_ioWindowRouter.sv
module test_ioWindowRouter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgSel = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgOffset = 8'h00;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic reqValid = 1'b0;
  logic [15:0] reqAddr = 16'h0000;
  logic rspValid;
  logic [1:0] rspCode;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ioWindowRouter i_ioWindowRouter (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgWrEn(cfgWrEn),
    .cfgOffset(cfgOffset), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid), .rspCode(rspCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [7:0] off, input logic [7:0] data);
    @(negedge clk);
    cfgSel = sel; cfgOffset = off; cfgWrData = data; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input logic sel, input logic [7:0] off, input logic [7:0] exp,
                         input string tag);
    @(negedge clk);
    cfgSel = sel; cfgOffset = off;
    #1 check(tag, cfgRdData, exp);
  endtask

  task automatic doReq(input logic [15:0] addr, input logic [1:0] exp, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr;
    @(negedge clk);
    check({tag, " valid"}, rspValid, 1);
    check(tag, rspCode, exp);
    reqValid = 1'b0;
    @(negedge clk);
    check("R9 pulse ends", {rspValid, rspCode}, 0);
  endtask

  task automatic testReset();
    check("R9 idle after reset", {rspValid, rspCode}, 0);
    cfgRead(0, 8'h1C, 8'h00, "R1 br0 base");
    cfgRead(0, 8'h1D, 8'h00, "R1 br0 limit");
    cfgRead(1, 8'h1C, 8'h00, "R1 br1 base");
    cfgRead(1, 8'h1D, 8'h00, "R1 br1 limit");
    doReq(16'h0FFF, 2'd1, "R1 R7 low 4K to br0");
    doReq(16'h1000, 2'd3, "R1 R6 above 4K UR");
  endtask

  task automatic testProgram();
    cfgWrite(0, 8'h1C, 8'h1F);
    cfgWrite(0, 8'h1D, 8'h3A);
    cfgWrite(1, 8'h1C, 8'h85);
    cfgWrite(1, 8'h1D, 8'h9F);
    cfgRead(0, 8'h1C, 8'h10, "R2 br0 base readback");
    cfgRead(0, 8'h1D, 8'h30, "R3 br0 limit readback");
    cfgRead(1, 8'h1C, 8'h80, "R2 br1 base readback");
    cfgRead(1, 8'h1D, 8'h90, "R3 br1 limit readback");
    doReq(16'h0FFF, 2'd3, "R6 below br0");
    doReq(16'h1000, 2'd1, "R5 br0 base edge");
    doReq(16'h3FFF, 2'd1, "R5 br0 limit edge");
    doReq(16'h4000, 2'd3, "R6 gap");
    doReq(16'h8000, 2'd2, "R5 br1 base edge");
    doReq(16'h9FFF, 2'd2, "R5 br1 limit edge");
    doReq(16'hA000, 2'd3, "R6 above br1");
  endtask

  task automatic testUpper();
    for (int off = 8'h30; off <= 8'h33; off++) cfgWrite(0, 8'(off), 8'hFF);
    cfgWrite(0, 8'h40, 8'hF0);
    for (int off = 8'h30; off <= 8'h33; off++) cfgRead(0, 8'(off), 8'h00, "R4 upper reads zero");
    cfgRead(0, 8'h1C, 8'h10, "R4 base untouched");
    cfgRead(0, 8'h1D, 8'h30, "R4 limit untouched");
    doReq(16'h0FFF, 2'd3, "R4 routing unchanged low");
    doReq(16'hF000, 2'd3, "R4 routing unchanged high");
  endtask

  task automatic testOverlap();
    cfgWrite(1, 8'h1C, 8'h20);
    cfgWrite(1, 8'h1D, 8'h50);
    doReq(16'h2500, 2'd1, "R7 overlap to br0");
    doReq(16'h4500, 2'd2, "R7 br1 alone");
  endtask

  task automatic testInverted();
    cfgWrite(0, 8'h1C, 8'h60);
    cfgWrite(0, 8'h1D, 8'h50);
    doReq(16'h5000, 2'd2, "R8 inverted br0 skipped");
    doReq(16'h6000, 2'd3, "R8 inverted br0 no match");
    doReq(16'h1000, 2'd3, "R8 inverted br0 old range");
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    cfgSel = 1'b1; cfgOffset = 8'h1D; cfgWrData = 8'h70; cfgWrEn = 1'b1;
    reqValid = 1'b1; reqAddr = 16'h6000;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    check("R10 same-cycle sees old", rspCode, 3);
    doReq(16'h6000, 2'd2, "R10 later sees new");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testProgram();
    testUpper();
    testOverlap();
    testInverted();
    testSameCycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule